// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates up to two pulse width modulated outputs from one system clock. Each channel first divides the clock through a prescaler. The divisor comes from a fixed table of sixteen codes, and one of those codes passes the clock through undivided. The divided tick drives a period counter. The output is at its active level while the counter is below the programmed duty count. A per-channel polarity bit chooses whether the active level is high or low.

Software reaches the block through a flat 32-bit register port with a select and a write strobe. One shared control word holds each channel's prescaler code, enable, polarity and clock gate, together with one ready flag per channel. A separate word per channel holds the period and the duty. A period/duty write made while the channel runs is held in a shadow copy and moves into the live copy only when the current period wraps, so the waveform never changes part-way through a period. The ready flag shows that a shadow value is still waiting. When the channel is stopped, a write takes effect on the next clock.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: The control word sits at byte address 0x0 and channel n's period/duty word at 0x4 + 4*n. `bus_rdata` shows the addressed word in the same cycle. A period/duty word reads back the value last written to it, and an unmapped address reads 0.
- R2: Channel n's control field starts at bit 15*n of the control word: bits [3:0] prescaler code, bit 4 enable, bit 5 active-high, bit 6 clock gate. Every other bit of the control word below bit 28 reads 0.
- R3: Prescaler codes 0, 1, 2, 3 and 4 give one counter tick every 120, 180, 240, 360 and 480 clocks.
- R4: Prescaler codes 8, 9, 10, 11 and 12 give one counter tick every 12000, 24000, 36000, 48000 and 72000 clocks.
- R5: Prescaler code 15 bypasses the divider and gives one tick every clock.
- R6: In the period/duty word, bits [31:16] hold P-1 and bits [15:0] hold the duty D. With divisor K, each period lasts P*K clocks. The first D*K clocks of each period are active and the remaining clocks are inactive. The first period starts in the first cycle after the channel starts.
- R7: With the active-high bit at 1 the active level is 1. With the bit at 0 the output is inverted: the active level is 0 and the inactive level is 1.
- R8: A channel runs only while both its enable bit and its gate bit are 1. Otherwise its output sits at the inactive level and its divider and period counter are held at zero. After reset all control bits are 0, so every output is 1.
- R9: A write to channel n's period/duty word sets the ready flag at control bit 28+n, visible in the cycle after the write.
- R10: While a channel runs, a written value waits until the current period ends. It becomes live in the first cycle of the next period, and the ready flag clears in that same cycle.
- R11: While a channel is stopped, a written value becomes live one clock after the write, and the ready flag clears then.
- R12: A duty of 0 holds the output at the inactive level. A duty of P or more holds it at the active level.
- R13: Prescaler codes 5, 6, 7, 13 and 14 are invalid. With an invalid code the running channel's divider and counter freeze, so the output level and any pending ready flag stay as they are until a valid code is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A wrong divider count or table entry shows up as high and low runs on `pwm_out` whose length is off by a multiple of the divisor. It is visible within the first period after the channel starts. A shadow copy that moves into the live copy at the wrong time shows up in two ways: the ready flag clears in a cycle other than the first cycle of the new period, or the period that was running is cut short. Both are visible at the first boundary after the write. A channel that keeps counting while stopped, or while it has an invalid code, moves the output or clears the ready flag within a few clocks, and the output is sampled on every clock while that happens.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

   localparam int REG_W     = 32;   // register width
   localparam int CW        = 16;   // period / duty field width
   localparam int DIV_W     = 17;   // wide enough for the largest divisor
   localparam int CTL_W     = 7;    // bits used in one channel control field
   localparam int CH_STRIDE = 15;   // control field spacing between channels
   localparam int RDY_BASE  = 28;   // ready flag of channel 0
   localparam int MAX_CH    = 2;
   localparam int PRD_BASE  = 4;
   localparam int PRD_STEP  = 4;

   typedef struct packed {
      logic       gate;
      logic       act_hi;
      logic       en;
      logic [3:0] code;
   } chan_ctl_t;

   function automatic logic [DIV_W-1:0] code_divisor(input logic [3:0] c, input bit byp);
      case (c)
         4'h0:    return DIV_W'(120);
         4'h1:    return DIV_W'(180);
         4'h2:    return DIV_W'(240);
         4'h3:    return DIV_W'(360);
         4'h4:    return DIV_W'(480);
         4'h8:    return DIV_W'(12000);
         4'h9:    return DIV_W'(24000);
         4'hA:    return DIV_W'(36000);
         4'hB:    return DIV_W'(48000);
         4'hC:    return DIV_W'(72000);
         4'hF:    return byp ? DIV_W'(1) : '0;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int DIV_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   logic [DIV_W-1:0] pcnt;
   logic             valid;
   logic             last;

   assign valid = divisor != '0;
   assign last  = pcnt >= (divisor - DIV_W'(1));
   assign tick  = run && valid && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
      end else if (valid) begin
         pcnt <= last ? '0 : pcnt + DIV_W'(1);
      end
   end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
   parameter int CW = 16,
   localparam int WW = 2 * CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          wr,
   input  logic [WW-1:0] wdata,
   input  logic          act_hi,
   output logic [WW-1:0] shadow,
   output logic          pend,
   output logic [CW-1:0] cnt,
   output logic          out
);

   logic [CW-1:0] live_prd;
   logic [CW-1:0] live_dty;
   logic          wrap;
   logic          boundary;
   logic          active;

   assign wrap     = tick && (cnt >= live_prd);
   assign boundary = !run || wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         live_prd <= '0;
         live_dty <= '0;
         shadow   <= '0;
         pend     <= 1'b0;
      end else begin
         if (!run)
            cnt <= '0;
         else if (tick)
            cnt <= wrap ? '0 : cnt + CW'(1);

         if (boundary && pend) begin
            live_prd <= shadow[WW-1:CW];
            live_dty <= shadow[CW-1:0];
         end

         if (wr) begin
            shadow <= wdata;
            pend   <= 1'b1;
         end else if (boundary) begin
            pend   <= 1'b0;
         end
      end
   end

   assign active = run && (cnt < live_dty);
   assign out    = active ? act_hi : ~act_hi;

endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
   import pwm_dual_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int ADDR_W     = 4,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic [NCH-1:0]    pwm_out
);

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("pwm_dual_ctrl: NCH must be between 1 and %0d", MAX_CH);
   end
   if ((2 ** ADDR_W) <= (PRD_BASE + PRD_STEP * (NCH - 1))) begin : g_bad_aw
      $error("pwm_dual_ctrl: ADDR_W too narrow for the channel registers");
   end

   chan_ctl_t          ctl_q [NCH];
   logic               ctl_hit;
   logic [NCH-1:0]     prd_hit;
   logic [NCH-1:0]     run_v;
   logic [NCH-1:0]     act_v;
   logic [NCH-1:0]     pend_v;
   logic [NCH-1:0]     wr_v;
   logic [NCH-1:0]     bad_v;
   logic [NCH*CW-1:0]  cnt_f;
   logic [REG_W-1:0]   shadow_w [NCH];

   assign ctl_hit = bus_addr == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < NCH; n++) ctl_q[n] <= '0;
      end else if (bus_sel && bus_we && ctl_hit) begin
         for (int n = 0; n < NCH; n++)
            ctl_q[n] <= chan_ctl_t'(bus_wdata[n*CH_STRIDE +: CTL_W]);
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic [DIV_W-1:0] div_n;
      logic             tick_n;

      assign prd_hit[n] = bus_addr == ADDR_W'(PRD_BASE + PRD_STEP * n);
      assign wr_v[n]    = bus_sel && bus_we && prd_hit[n];
      assign div_n      = code_divisor(ctl_q[n].code, HAS_BYPASS);
      assign run_v[n]   = ctl_q[n].en && ctl_q[n].gate;
      assign act_v[n]   = ctl_q[n].act_hi;
      assign bad_v[n]   = div_n == '0;

      pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_v[n]),
         .divisor (div_n),
         .tick    (tick_n)
      );

      pwm_chan_core #(.CW(CW)) u_core (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run_v[n]),
         .tick   (tick_n),
         .wr     (wr_v[n]),
         .wdata  (bus_wdata),
         .act_hi (act_v[n]),
         .shadow (shadow_w[n]),
         .pend   (pend_v[n]),
         .cnt    (cnt_f[n*CW +: CW]),
         .out    (pwm_out[n])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (ctl_hit) begin
         for (int n = 0; n < NCH; n++) begin
            bus_rdata[n*CH_STRIDE +: CTL_W] = ctl_q[n];
            bus_rdata[RDY_BASE + n]         = pend_v[n];
         end
      end
      for (int n = 0; n < NCH; n++)
         if (prd_hit[n]) bus_rdata = shadow_w[n];
   end

endmodule

// File: rtl/pwm_dual_ctrl_chk.sv
module pwm_dual_ctrl_chk
   import pwm_dual_pkg::*;
#(
   parameter int NCH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NCH-1:0]    pwm_out,
   input logic [NCH-1:0]    run_v,
   input logic [NCH-1:0]    act_v,
   input logic [NCH-1:0]    pend_v,
   input logic [NCH-1:0]    wr_v,
   input logic [NCH-1:0]    bad_v,
   input logic [NCH*CW-1:0] cnt_f
);

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      logic [CW-1:0] c;
      assign c = cnt_f[i*CW +: CW];

      // R8
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run_v[i] |-> (pwm_out[i] == ~act_v[i]));

      // R8
      idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run_v[i] |=> (c == '0));

      // R9
      ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_v[i] |=> pend_v[i]);

      // R10
      ready_clear_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_v[i]) |-> (c == '0));

      // R11
      stopped_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_v[i] && pend_v[i] && !wr_v[i]) |=> !pend_v[i]);

      // R13
      bad_code_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_v[i] && bad_v[i]) |=> $stable(c));
   end

endmodule

bind pwm_dual_ctrl pwm_dual_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pwm_out (pwm_out),
   .run_v   (run_v),
   .act_v   (act_v),
   .pend_v  (pend_v),
   .wr_v    (wr_v),
   .bad_v   (bad_v),
   .cnt_f   (cnt_f)
);

// File: tb/tb_pwm_dual_ctrl.sv
module tb_pwm_dual_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   wire  [31:0] bus_rdata;
   wire  [1:0]  pwm_out;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwm_dual_ctrl #(.NCH(2), .ADDR_W(4), .HAS_BYPASS(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic run_len(input int ch, input logic lvl, input int lim, output int n);
      n = 0;
      while (pwm_out[ch] === lvl && n < lim) begin
         n++;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] cw(input int ch, input logic [3:0] code,
                                      input logic en, input logic act, input logic gate);
      return 32'({gate, act, en, code}) << (15 * ch);
   endfunction

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      int n;
      int codes [6] = '{0, 1, 2, 3, 4, 15};
      int divs  [6] = '{120, 180, 240, 360, 480, 1};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(4'h0, d); check("R8 reset ctrl", d, 32'h0);
      rd(4'h4, d); check("R1 reset ch0 word", d, 32'h0);
      check("R8 reset outputs idle high", 32'(pwm_out), 32'h3);

      // R1 register map and read back
      wr(4'h4, 32'h0009_0003);
      rd(4'h4, d); check("R1 ch0 readback", d, 32'h0009_0003);
      wr(4'h8, 32'h1234_5678);
      rd(4'h8, d); check("R1 ch1 readback", d, 32'h1234_5678);
      rd(4'hC, d); check("R1 unmapped reads 0", d, 32'h0);

      // R2 field layout and reserved bits
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R2 reserved bits zero", d, 32'h003F_807F);
      wr(4'h0, cw(1, 4'hA, 1'b1, 1'b0, 1'b1));
      rd(4'h0, d); check("R2 channel 1 field position", d, 32'h002D_0000);
      wr(4'h0, 32'h0);

      // R3 R5 R6 R7: small codes and bypass on both channels with opposite polarity
      for (int k = 0; k < 6; k++) begin
         int k1;
         int h0, l0, h1, l1;
         k1 = 5 - k;
         wr(4'h0, 32'h0);
         wr(4'h4, 32'h0003_0001);
         wr(4'h8, 32'h0002_0002);
         wr(4'h0, cw(0, 4'(codes[k]), 1'b1, 1'b1, 1'b1) | cw(1, 4'(codes[k1]), 1'b1, 1'b0, 1'b1));
         fork
            begin run_len(0, 1'b1, 10000, h0); run_len(0, 1'b0, 10000, l0); end
            begin run_len(1, 1'b0, 10000, h1); run_len(1, 1'b1, 10000, l1); end
         join
         check((codes[k] == 15) ? "R5 bypass active run" : "R3 active run", h0, divs[k]);
         check("R6 inactive run", l0, 3 * divs[k]);
         check("R7 inverted active run", h1, 2 * divs[k1]);
         check("R7 inverted inactive run", l1, divs[k1]);
      end

      // R4: large codes, active run only, two channels in parallel
      begin
         int h0, h1;
         wr(4'h0, 32'h0);
         wr(4'h4, 32'h0001_0001);
         wr(4'h8, 32'h0001_0001);
         wr(4'h0, cw(0, 4'hC, 1'b1, 1'b1, 1'b1) | cw(1, 4'hB, 1'b1, 1'b1, 1'b1));
         fork
            run_len(0, 1'b1, 80000, h0);
            run_len(1, 1'b1, 80000, h1);
         join
         check("R4 code 12", h0, 72000);
         check("R4 code 11", h1, 48000);
         wr(4'h0, 32'h0);
         wr(4'h0, cw(0, 4'hA, 1'b1, 1'b1, 1'b1) | cw(1, 4'h9, 1'b1, 1'b1, 1'b1));
         fork
            run_len(0, 1'b1, 80000, h0);
            run_len(1, 1'b1, 80000, h1);
         join
         check("R4 code 10", h0, 36000);
         check("R4 code 9", h1, 24000);
         wr(4'h0, 32'h0);
         wr(4'h0, cw(0, 4'h8, 1'b1, 1'b1, 1'b1));
         run_len(0, 1'b1, 80000, h0);
         check("R4 code 8", h0, 12000);
      end

      // R9 R10: update while running waits for the period boundary
      begin
         logic po, pr;
         int guard, h, l;
         wr(4'h0, 32'h0);
         wr(4'h4, 32'h0009_0003);
         wr(4'h0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1));
         repeat (4) @(negedge clk);
         wr(4'h4, 32'h0005_0002);
         rd(4'h0, d);
         check("R9 ready set after write", 32'(d[28]), 32'h1);
         po = pwm_out[0];
         pr = d[28];
         guard = 0;
         while (guard < 50) begin
            @(negedge clk);
            rd(4'h0, d);
            if (po == 1'b0 && pwm_out[0] == 1'b1) break;
            po = pwm_out[0];
            pr = d[28];
            guard++;
         end
         check("R10 old period completes", guard, 3);
         check("R10 ready clear in first cycle of new period", 32'(d[28]), 32'h0);
         check("R10 ready still set in last old cycle", 32'(pr), 32'h1);
         run_len(0, 1'b1, 50, h);
         run_len(0, 1'b0, 50, l);
         check("R6 new duty active run", h, 2);
         check("R6 new period inactive run", l, 4);
      end

      // R12: duty 0 and duty at or above the period
      wr(4'h0, 32'h0);
      wr(4'h4, 32'h0004_0000);
      wr(4'h0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1));
      run_len(0, 1'b0, 40, n);
      check("R12 duty 0 constant inactive", n, 40);
      wr(4'h4, 32'h0004_0007);
      repeat (6) @(negedge clk);
      run_len(0, 1'b1, 40, n);
      check("R12 duty above period constant active", n, 40);

      // R13: invalid codes freeze the channel
      begin
         logic o;
         int bad;
         logic [3:0] badc [5] = '{4'h5, 4'h6, 4'h7, 4'hD, 4'hE};
         wr(4'h0, cw(0, 4'h5, 1'b1, 1'b1, 1'b1));
         o = pwm_out[0];
         wr(4'h4, 32'h0009_0005);
         for (int j = 0; j < 5; j++) begin
            wr(4'h0, cw(0, badc[j], 1'b1, 1'b1, 1'b1));
            bad = 0;
            repeat (20) begin
               @(negedge clk);
               if (pwm_out[0] !== o) bad++;
            end
            check("R13 output frozen", bad, 0);
            rd(4'h0, d);
            check("R13 ready held", 32'(d[28]), 32'h1);
         end
         wr(4'h0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1));
         repeat (12) @(negedge clk);
         rd(4'h0, d);
         check("R13 valid code resumes and applies", 32'(d[28]), 32'h0);
      end

      // R8 R11: gating, stopped writes apply at once
      begin
         int h, l;
         wr(4'h0, cw(0, 4'hF, 1'b1, 1'b1, 1'b0));
         run_len(0, 1'b0, 20, n);
         check("R8 gate off holds inactive", n, 20);
         wr(4'h4, 32'h0003_0002);
         rd(4'h0, d);
         check("R9 ready set while stopped", 32'(d[28]), 32'h1);
         @(negedge clk);
         rd(4'h0, d);
         check("R11 stopped write applies next clock", 32'(d[28]), 32'h0);
         wr(4'h0, cw(0, 4'hF, 1'b0, 1'b1, 1'b1));
         run_len(0, 1'b0, 20, n);
         check("R8 enable off holds inactive", n, 20);
         wr(4'h0, cw(0, 4'hF, 1'b0, 1'b0, 1'b1));
         check("R7 R8 inverted idle level", 32'(pwm_out[0]), 32'h1);
         wr(4'h0, cw(0, 4'hF, 1'b1, 1'b1, 1'b1));
         run_len(0, 1'b1, 50, h);
         run_len(0, 1'b0, 50, l);
         check("R11 stopped value live at start active", h, 2);
         check("R11 stopped value live at start inactive", l, 2);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule